// File: doc/BRIEF.md
# Ethernet switch port LED controller

This block drives the status LEDs of a five-port Ethernet switch. Each port has three LEDs, which gives fifteen outputs. Software programs the LEDs through four 32-bit control registers on a simple register bus. The bus has a byte address, write data, a write strobe, and read data that is registered.

Each LED has a 2-bit mode. The four modes are:
- dark
- forced lit
- a fixed blink
- following an activity rule

There are six rules, one for each LED index. The first set of three is shared by ports 0 to 3. The second set of three belongs to port 4. A rule combines the port's own inputs with a selectable blink rate:
- link state
- link speed
- duplex
- transmit, receive and collision activity

All blink rates come from one prescaler. The prescaler produces a 16 Hz tick from the `CLK_HZ` parameter, so LEDs blinking at the same rate stay in phase. Activity pulses are stretched so that even a one-cycle event shows as a visible blink.

Top module: `port_led_ctrl`

## Requirements
- R1: A synchronous reset clears all four registers, the read data, the stretch counters and the blink phase. Every LED is then dark.
- R2: The registers sit at byte addresses 0x50, 0x54, 0x58 and 0x5C. A write takes effect at the clock edge. Read data for the address on the bus appears on the clock edge that follows. Any other address, unaligned addresses included, reads as zero and ignores writes.
- R3: The mode code of each LED selects its behaviour: 0 dark, 1 blink, 2 lit, 3 rule. LED k = 3*port + index is driven on `led_out[k]`. Port 0, index i, uses bits 15:14 of register i. Port 4, index i, uses bits 31:30 of register i. Ports 1 to 3 use register 3 at bit offset 8 + 2*i + 6*(port-1).
- R4: A 16 Hz tick fires once every `CLK_HZ/16` clocks and advances a 3-bit phase. The 8 Hz, 4 Hz and 2 Hz waves toggle every 1, 2 and 4 ticks. Each wave is lit in the second half of its period. A mode-1 LED shows the 4 Hz wave.
- R5: Ports 0 to 3 take the rule for LED index i from register i, bits 13:0. Port 4 takes it from register i, bits 29:16.
- R6: In rule mode the link qualifies when all of these hold:
  - `link_up` is high.
  - The speed code has its enable bit set: code 0 is 10 Mb/s and uses bit 8, code 1 is 100 Mb/s and uses bit 9, code 2 is 1000 Mb/s and uses bit 10. Code 3 never qualifies.
  - The duplex matches an enabled duplex bit: bit 12 for half, bit 13 for full. If neither duplex bit is set, duplex is ignored.

  A qualified link without shown activity lights the LED steadily.
- R7: Transmit (rule bit 4), receive (bit 5) and collision (bit 6+1=7) activity are enabled separately. Each input holds its stretched flag for `STRETCH_TICKS` ticks after it drops. While an enabled flag is held, the LED shows the selected blink wave. If rule bit 2 is set, activity is shown only while the link qualifies.
- R8: Rule bits 1:0 select the activity rate: 0 is 2 Hz, 1 is 4 Hz, 2 is 8 Hz. Code 3 picks the rate by speed: 8 Hz at 1000, 4 Hz at 100, and 2 Hz at 10 Mb/s or an invalid speed.
- R9: In rule mode, with rule bit 11 set, the LED is lit while `por_hold` is high. This overrides link and activity.
- R10: The LED outputs are registered. A register write or an input change shows one clock later. A new activity event shows two clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst | input | 1 | synchronous active-high reset |
| bus_addr | input | ADDR_W | byte address |
| bus_wdata | input | 32 | write data |
| bus_we | input | 1 | write strobe |
| bus_rdata | output | 32 | registered read data |
| link_up | input | 5 | per-port link state |
| link_speed | input | 10 | 2-bit speed code per port, port p at bits 2p+1:2p |
| full_duplex | input | 5 | per-port duplex, 1 = full |
| tx_act | input | 5 | per-port transmit activity |
| rx_act | input | 5 | per-port receive activity |
| col_act | input | 5 | per-port collision indication |
| por_hold | input | 1 | power-on status hold |
| led_out | output | 15 | LED drive, LED k = 3*port + index |

## Verification
On every cycle the assertions check these behaviours:
- forced dark and forced lit LEDs follow their code one clock later;
- forced blink copies the 4 Hz phase bit;
- a rule LED with the power-on light bit is lit while `por_hold` is high;
- the phase moves only on a tick;
- stretch counters never exceed their load value;
- unmapped reads return zero.

Some properties need whole scenarios, which the bench compares against a behavioural model on every clock:
- the scattered field placement for ports 1 to 3;
- the split of rule sets between the two port groups;
- link and duplex qualification;
- automatic rate choice;
- the length of the activity stretch.

// File: rtl/port_led_pkg.sv
package port_led_pkg;
  localparam int NUM_PORTS     = 5;
  localparam int LEDS_PER_PORT = 3;
  localparam int NUM_LEDS      = NUM_PORTS * LEDS_PER_PORT;
  localparam int NUM_REGS      = 4;
  localparam int RULE_W        = 14;
  localparam int NUM_EVT       = 3;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_BLINK = 2'd1,
    MODE_ON    = 2'd2,
    MODE_RULE  = 2'd3
  } led_mode_e;

  typedef logic [RULE_W-1:0] rule_t;

  // rule bit positions
  localparam int RB_NEEDLINK = 2;
  localparam int RB_TX       = 4;
  localparam int RB_RX       = 5;
  localparam int RB_COL      = 7;
  localparam int RB_SPD10    = 8;
  localparam int RB_SPD100   = 9;
  localparam int RB_SPD1000  = 10;
  localparam int RB_PORLIT   = 11;
  localparam int RB_HALF     = 12;
  localparam int RB_FULL     = 13;
endpackage

// File: rtl/port_led_regs.sv
module port_led_regs
  import port_led_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 'h50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic              we,
  output logic [31:0]       rdata,
  output logic [31:0]       regs_q [NUM_REGS]
);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BASE_ADDR);

  logic [ADDR_W-1:0] off;
  logic              hit;
  logic [1:0]        idx;

  assign off = addr - BASE;
  assign hit = (off[ADDR_W-1:4] == '0) && (off[1:0] == 2'b00);
  assign idx = off[3:2];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NUM_REGS; r++) regs_q[r] <= '0;
      rdata <= '0;
    end else begin
      if (we && hit) regs_q[idx] <= wdata;
      rdata <= hit ? regs_q[idx] : '0;
    end
  end

  p_rd_unmapped_r2: assert property (@(posedge clk) disable iff (rst)
    !hit |=> (rdata == '0));
  p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
    (we && hit) |=> (regs_q[$past(idx)] == $past(wdata)));
endmodule

// File: rtl/port_led_map.sv
module port_led_map
  import port_led_pkg::*;
(
  input  logic [31:0] regs_q [NUM_REGS],
  output led_mode_e   mode   [NUM_LEDS],
  output rule_t       rule   [NUM_LEDS]
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    for (genvar i = 0; i < LEDS_PER_PORT; i++) begin : g_led
      localparam int K = p * LEDS_PER_PORT + i;
      if (p == 0) begin : g_first
        assign mode[K] = led_mode_e'(regs_q[i][15:14]);
      end else if (p == NUM_PORTS - 1) begin : g_last
        assign mode[K] = led_mode_e'(regs_q[i][31:30]);
      end else begin : g_mid
        assign mode[K] = led_mode_e'(regs_q[3][8 + 2*i + 6*(p-1) +: 2]);
      end
      if (p == NUM_PORTS - 1) begin : g_rule_hi
        assign rule[K] = regs_q[i][29:16];
      end else begin : g_rule_lo
        assign rule[K] = regs_q[i][13:0];
      end
    end
  end

  logic unused_bits;
  assign unused_bits = ^{regs_q[3][31:26], regs_q[3][7:0]};
endmodule

// File: rtl/port_led_blink.sv
module port_led_blink #(
  parameter int CLK_HZ  = 50_000_000,
  parameter int TICK_HZ = 16
) (
  input  logic       clk,
  input  logic       rst,
  output logic       tick,
  output logic [2:0] phase
);
  localparam int DIV   = (CLK_HZ / TICK_HZ < 1) ? 1 : CLK_HZ / TICK_HZ;
  localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CNT_W-1:0] cnt;

  assign tick = (cnt == CNT_W'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      phase <= '0;
    end else if (tick) begin
      cnt   <= '0;
      phase <= phase + 3'd1;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  p_phase_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(phase));
endmodule

// File: rtl/port_led_activity.sv
module port_led_activity
  import port_led_pkg::*;
#(
  parameter int STRETCH_TICKS = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           tick,
  input  logic [NUM_EVT*NUM_PORTS-1:0]   ev_in,
  output logic [NUM_EVT*NUM_PORTS-1:0]   ev_held
);
  localparam int SW = $clog2(STRETCH_TICKS + 1);

  for (genvar j = 0; j < NUM_EVT * NUM_PORTS; j++) begin : g_ev
    logic [SW-1:0] cnt;
    always_ff @(posedge clk) begin
      if (rst)                      cnt <= '0;
      else if (ev_in[j])            cnt <= SW'(STRETCH_TICKS);
      else if (tick && cnt != '0)   cnt <= cnt - SW'(1);
    end
    assign ev_held[j] = (cnt != '0);

    p_stretch_cap_r7: assert property (@(posedge clk) disable iff (rst)
      cnt <= SW'(STRETCH_TICKS));
    p_event_seen_r7: assert property (@(posedge clk) disable iff (rst)
      ev_in[j] |=> ev_held[j]);
  end
endmodule

// File: rtl/port_led_cell.sv
module port_led_cell
  import port_led_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  led_mode_e  mode,
  input  rule_t      rule,
  input  logic [2:0] phase,
  input  logic       link_up,
  input  logic [1:0] speed,
  input  logic       full_dup,
  input  logic       tx_h,
  input  logic       rx_h,
  input  logic       col_h,
  input  logic       por_hold,
  output logic       led
);
  logic       spd_ok, dup_ok, link_ok, act, show_act, wave, rule_lvl, nxt;
  logic [1:0] rate;

  always_comb begin
    case (speed)
      2'd0:    spd_ok = link_up && rule[RB_SPD10];
      2'd1:    spd_ok = link_up && rule[RB_SPD100];
      2'd2:    spd_ok = link_up && rule[RB_SPD1000];
      default: spd_ok = 1'b0;
    endcase
    if (!rule[RB_HALF] && !rule[RB_FULL]) dup_ok = 1'b1;
    else dup_ok = full_dup ? rule[RB_FULL] : rule[RB_HALF];
    link_ok  = spd_ok && dup_ok;
    act      = (rule[RB_TX] && tx_h) || (rule[RB_RX] && rx_h) || (rule[RB_COL] && col_h);
    show_act = act && (!rule[RB_NEEDLINK] || link_ok);

    if (rule[1:0] == 2'd3) begin
      case (speed)
        2'd2:    rate = 2'd2;
        2'd1:    rate = 2'd1;
        default: rate = 2'd0;
      endcase
    end else begin
      rate = rule[1:0];
    end
    case (rate)
      2'd2:    wave = phase[0];
      2'd1:    wave = phase[1];
      default: wave = phase[2];
    endcase

    if (por_hold && rule[RB_PORLIT]) rule_lvl = 1'b1;
    else if (show_act)               rule_lvl = wave;
    else                             rule_lvl = link_ok;

    case (mode)
      MODE_OFF:   nxt = 1'b0;
      MODE_BLINK: nxt = phase[1];
      MODE_ON:    nxt = 1'b1;
      default:    nxt = rule_lvl;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) led <= 1'b0;
    else     led <= nxt;
  end

  logic unused_rule;
  assign unused_rule = ^{rule[3], rule[6]};

  p_forced_on_r3: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_ON) |=> led);
  p_forced_off_r3: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_OFF) |=> !led);
  p_blink_follow_r4: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_BLINK) |=> (led == $past(phase[1])));
  p_por_light_r9: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_RULE && por_hold && rule[RB_PORLIT]) |=> led);
endmodule

// File: rtl/port_led_ctrl.sv
module port_led_ctrl
  import port_led_pkg::*;
#(
  parameter int CLK_HZ        = 50_000_000,
  parameter int STRETCH_TICKS = 8,
  parameter int ADDR_W        = 8,
  parameter int BASE_ADDR     = 'h50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  output logic [31:0]       bus_rdata,
  input  logic [4:0]        link_up,
  input  logic [9:0]        link_speed,
  input  logic [4:0]        full_duplex,
  input  logic [4:0]        tx_act,
  input  logic [4:0]        rx_act,
  input  logic [4:0]        col_act,
  input  logic              por_hold,
  output logic [14:0]       led_out
);
  logic [31:0] regs_q [NUM_REGS];
  led_mode_e   mode   [NUM_LEDS];
  rule_t       rule   [NUM_LEDS];
  logic        tick;
  logic [2:0]  phase;
  logic [NUM_EVT*NUM_PORTS-1:0] ev_held;

  port_led_regs #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .wdata(bus_wdata), .we(bus_we),
    .rdata(bus_rdata), .regs_q(regs_q)
  );

  port_led_map u_map (.regs_q(regs_q), .mode(mode), .rule(rule));

  port_led_blink #(.CLK_HZ(CLK_HZ)) u_blink (
    .clk(clk), .rst(rst), .tick(tick), .phase(phase)
  );

  port_led_activity #(.STRETCH_TICKS(STRETCH_TICKS)) u_act (
    .clk(clk), .rst(rst), .tick(tick),
    .ev_in({col_act, rx_act, tx_act}), .ev_held(ev_held)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    for (genvar i = 0; i < LEDS_PER_PORT; i++) begin : g_led
      localparam int K = p * LEDS_PER_PORT + i;
      port_led_cell u_cell (
        .clk(clk), .rst(rst), .mode(mode[K]), .rule(rule[K]), .phase(phase),
        .link_up(link_up[p]), .speed(link_speed[2*p +: 2]),
        .full_dup(full_duplex[p]),
        .tx_h(ev_held[p]), .rx_h(ev_held[NUM_PORTS + p]),
        .col_h(ev_held[2*NUM_PORTS + p]),
        .por_hold(por_hold), .led(led_out[K])
      );
    end
  end

  p_reset_dark_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (led_out == '0 && bus_rdata == '0));
endmodule

// File: tb/port_led_ctrl_bench.sv
module port_led_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 160;
  localparam int STRETCH    = 8;
  localparam int DIV        = CLK_HZ / 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic [4:0]  link_up = '0;
  logic [9:0]  link_speed = '0;
  logic [4:0]  full_duplex = '0;
  logic [4:0]  tx_act = '0, rx_act = '0, col_act = '0;
  logic        por_hold = 1'b0;
  logic [14:0] led_out;

  port_led_ctrl #(.CLK_HZ(CLK_HZ), .STRETCH_TICKS(STRETCH)) u_port_led_ctrl (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .link_up(link_up),
    .link_speed(link_speed), .full_duplex(full_duplex), .tx_act(tx_act),
    .rx_act(rx_act), .col_act(col_act), .por_hold(por_hold), .led_out(led_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    checks = 0;
  int    failures = 0;
  string cur_req = "R1";

  // behavioural reference state
  int          m_cnt, m_phase;
  logic [31:0] m_regs [4];
  int          m_str [3][5];
  logic [14:0] exp_led;
  logic [31:0] exp_rd;
  bit          armed = 0;

  function automatic logic [1:0] m_mode(int p, int i);
    if (p == 0)      return m_regs[i][15:14];
    else if (p == 4) return m_regs[i][31:30];
    else             return 2'((m_regs[3] >> (8 + 2*i + 6*(p-1))) & 32'h3);
  endfunction

  function automatic logic m_eval(int p, int i);
    logic [13:0] ru;
    int spd, rate, hp;
    bit sok, dok, lk, act, show, wave;
    ru  = (p == 4) ? m_regs[i][29:16] : m_regs[i][13:0];
    spd = int'(link_speed[2*p +: 2]);
    sok = link_up[p] && ((spd == 0 && ru[8]) || (spd == 1 && ru[9]) || (spd == 2 && ru[10]));
    if (!ru[12] && !ru[13]) dok = 1;
    else dok = full_duplex[p] ? ru[13] : ru[12];
    lk   = sok && dok;
    act  = (ru[4] && m_str[0][p] > 0) || (ru[5] && m_str[1][p] > 0) || (ru[7] && m_str[2][p] > 0);
    show = act && (!ru[2] || lk);
    rate = int'(ru[1:0]);
    if (rate == 3) rate = (spd == 2) ? 2 : (spd == 1) ? 1 : 0;
    hp   = (rate == 2) ? 1 : (rate == 1) ? 2 : 4;
    wave = ((m_phase / hp) % 2) == 1;
    case (m_mode(p, i))
      2'd0: return 1'b0;
      2'd1: return ((m_phase / 2) % 2) == 1;
      2'd2: return 1'b1;
      default: begin
        if (por_hold && ru[11]) return 1'b1;
        if (show) return wave;
        return lk;
      end
    endcase
  endfunction

  always @(posedge clk) begin
    logic [14:0] nl;
    logic [31:0] nrd;
    bit hit;
    int a;
    if (rst) begin
      m_cnt = 0; m_phase = 0; exp_led = '0; exp_rd = '0;
      for (int r = 0; r < 4; r++) m_regs[r] = '0;
      for (int t = 0; t < 3; t++) for (int p = 0; p < 5; p++) m_str[t][p] = 0;
      armed = 1;
    end else begin
      for (int p = 0; p < 5; p++)
        for (int i = 0; i < 3; i++) nl[p*3+i] = m_eval(p, i);
      a   = int'(bus_addr);
      hit = (a >= 'h50) && (a < 'h60) && (a % 4 == 0);
      nrd = hit ? m_regs[(a - 'h50) / 4] : '0;
      if (bus_we && hit) m_regs[(a - 'h50) / 4] = bus_wdata;
      for (int p = 0; p < 5; p++) begin
        for (int t = 0; t < 3; t++) begin
          bit ev;
          ev = (t == 0) ? tx_act[p] : (t == 1) ? rx_act[p] : col_act[p];
          if (ev) m_str[t][p] = STRETCH;
          else if (m_cnt == DIV - 1 && m_str[t][p] > 0) m_str[t][p] = m_str[t][p] - 1;
        end
      end
      if (m_cnt == DIV - 1) begin m_cnt = 0; m_phase = (m_phase + 1) % 8; end
      else m_cnt = m_cnt + 1;
      exp_led = nl;
      exp_rd  = nrd;
    end
  end

  // R10: outputs compared every clock against the one-cycle-registered model
  always @(negedge clk) begin
    if (armed) begin
      checks++;
      if (led_out !== exp_led) begin
        failures++;
        $display("FAIL %s led_out actual=%h expected=%h at %0t", cur_req, led_out, exp_led, $time);
      end
      checks++;
      if (bus_rdata !== exp_rd) begin
        failures++;
        $display("FAIL %s bus_rdata actual=%h expected=%h at %0t", cur_req, bus_rdata, exp_rd, $time);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a);
    @(negedge clk);
    bus_addr = a;
    repeat (2) @(negedge clk);
  endtask

  task automatic set_all(input logic [31:0] r0, r1, r2, r3);
    wr(8'h50, r0); wr(8'h54, r1); wr(8'h58, r2); wr(8'h5C, r3);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cur_req = "R1";
    repeat (4) @(negedge clk);
    rst = 1'b0;
    rd(8'h50);
    idle(20);

    cur_req = "R2";
    set_all(32'h1234_0001, 32'h0000_5A5A, 32'hFFFF_0000, 32'hFC00_00FF);
    rd(8'h50); rd(8'h54); rd(8'h58); rd(8'h5C);
    wr(8'h60, 32'hDEAD_BEEF); rd(8'h60);
    wr(8'h51, 32'hCAFE_F00D); rd(8'h51); rd(8'h50);
    rd(8'h4C);

    cur_req = "R3";
    set_all(32'h0000_8000, 32'h8000_0000, 32'h8000_8000, 32'h0202_0200);
    idle(40);
    set_all(32'h4000_8000, 32'h8000_4000, 32'h0000_0000, 32'h0109_0610);
    idle(60);

    cur_req = "R4";
    set_all(32'h4000_4000, 32'h4000_4000, 32'h4000_4000, 32'h0155_5500);
    idle(400);

    cur_req = "R5";
    set_all(32'hC200_E400, 32'hC200_E400, 32'hC200_E400, 32'h03FF_FF00);
    link_up = 5'b11111; link_speed = 10'b01_10_10_10_10; full_duplex = 5'b11111;
    idle(30);
    link_speed = 10'b10_01_01_10_01;
    idle(30);

    cur_req = "R6";
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      link_up     = 5'(k * 7 + 3);
      link_speed  = 10'(k * 13 + 5) ^ 10'(k << 5);
      full_duplex = 5'(k * 11);
      idle(15);
    end
    set_all(32'hC000_C700, 32'hC000_D100, 32'hC000_E400, 32'h03FF_FF00);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      link_up = 5'b11111; link_speed = 10'(k * 37); full_duplex = 5'(k * 9);
      idle(15);
    end

    cur_req = "R7";
    set_all(32'hC733_C711, 32'hC733_C724, 32'hC733_C782, 32'h03FF_FF00);
    link_up = 5'b10101; link_speed = 10'b10_10_01_00_10; full_duplex = 5'b11111;
    @(negedge clk); tx_act = 5'b11111; @(negedge clk); tx_act = '0;
    idle(150);
    @(negedge clk); rx_act = 5'b11111;
    idle(40);
    @(negedge clk); rx_act = '0;
    idle(150);
    @(negedge clk); col_act = 5'b01110; idle(3); col_act = '0;
    idle(120);

    cur_req = "R8";
    for (int s = 0; s < 4; s++) begin
      logic [31:0] rv;
      rv = 32'hC000_C000 | (32'(16'h0730 | s) << 16) | 32'(16'h0730 | s);
      set_all(rv, rv, rv, 32'h03FF_FF00);
      @(negedge clk);
      link_up = 5'b11111; link_speed = 10'b00_01_10_11_10;
      tx_act = 5'b11111;
      idle(200);
    end
    tx_act = '0;

    cur_req = "R9";
    set_all(32'hC800_C800, 32'hC000_C800, 32'hC800_C000, 32'h03FF_FF00);
    link_up = '0;
    idle(10);
    @(negedge clk); por_hold = 1'b1;
    idle(30);
    @(negedge clk); por_hold = 1'b0;
    idle(20);

    cur_req = "R1";
    set_all(32'h8000_8000, 32'h8000_8000, 32'h8000_8000, 32'h03FF_FF00);
    @(negedge clk); tx_act = 5'b11111;
    @(negedge clk); rst = 1'b1;
    idle(3);
    @(negedge clk); rst = 1'b0; tx_act = '0;
    rd(8'h54);
    idle(30);

    cur_req = "R10";
    wr(8'h50, 32'h8000_0000);
    idle(5);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule